// File: doc/BRIEF.md
# Modem Line Change Detector

This block watches four incoming modem handshake lines (carrier detect, ring indicator, data-set-ready and clear-to-send). Each line is brought into the local clock domain through a flop chain. The block shows the current level of each line and keeps a sticky change flag for it. Software clears a flag by writing a 1 to its bit. While any flag is set, the block raises a single change event toward the interrupt controller.

The ring-indicator flag differs from the other three. It records only the end of a ring, which is the line going from asserted to deasserted. The carrier, data-set-ready and clear-to-send flags record a transition in either direction.

The block also holds the two outgoing handshake controls, DTR and RTS, and an automatic flow-control enable. The flow-control mechanism itself lives elsewhere. A read/write flow-mode bit sits beside the status fields.

Top module: `modem_line_monitor`

## Requirements
- R1: After reset, `stat_o`, `ctrl_o`, `dtr_o`, `rts_o`, `auto_flow_o` and `chg_irq_o` are all 0.
- R2: Status bits 7, 6, 5 and 4 show the levels of carrier, ring, data-set-ready and clear-to-send. Each shows its pin as sampled at the clock edge two edges earlier.
- R3: Status bits 3 (carrier), 1 (data-set-ready) and 0 (clear-to-send) set one edge after the synchronised level changes in either direction. They stay set until cleared.
- R4: Status bit 2 sets only when the synchronised ring level falls from 1 to 0. A rising ring level leaves it unchanged.
- R5: A write with `stat_we_i`=1 clears each of status bits 3..0 whose `wdata_i` bit is 1. Bits written 0 are unchanged.
- R6: When a flag's edge is detected in the same cycle as a write that clears that flag, the flag ends up set.
- R7: `chg_irq_o` is 1 exactly when at least one of status bits 3..0 is set.
- R8: Status bit 8 is a read/write flow-mode bit, loaded from `wdata_i[8]` on a status write.
- R9: A write with `ctrl_we_i`=1 loads three controls: `wdata_i[0]` drives `dtr_o`, `wdata_i[1]` drives `rts_o`, and `wdata_i[5]` drives `auto_flow_o`. `ctrl_o` reads these back at bits 0, 1 and 5, with its other bits 0. With no write, all three hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dcd_i | input | 1 | Raw carrier-detect line |
| ri_i | input | 1 | Raw ring-indicator line |
| dsr_i | input | 1 | Raw data-set-ready line |
| cts_i | input | 1 | Raw clear-to-send line |
| stat_we_i | input | 1 | Status write strobe (write-1-to-clear flags, load flow-mode bit) |
| ctrl_we_i | input | 1 | Control write strobe |
| wdata_i | input | 9 | Write data for both registers |
| stat_o | output | 9 | Status readback: flow mode, levels, change flags |
| ctrl_o | output | 6 | Control readback |
| dtr_o | output | 1 | DTR output |
| rts_o | output | 1 | RTS output |
| auto_flow_o | output | 1 | Automatic flow-control enable |
| chg_irq_o | output | 1 | Modem-status-change event |

## Verification
The assertions take for granted that every input is sampled only at clock edges. They also take for granted that a status flag can fall only through a status write. For that reason the interrupt-hold property is qualified by the write strobe and not by the write data. The stimulus drives the pins and strobes only at falling clock edges, which is half a cycle away from the sampling edge. The random mix toggles each line at about one cycle in eight and issues status writes with random data. This exercises edges, clears and their coincidence inside the two assumed windows. Directed sequences place a clear exactly in the cycle where a change flag sets, and walk the ring line up and then down.

// File: rtl/modem_mon_pkg.sv
package modem_mon_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned STAT_W    = 9;
  localparam int unsigned CTRL_W    = 6;
  // line index doubles as flag bit position; level sits at index + NUM_LINES
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;
  localparam int unsigned FLOW_MODE_BIT = 8;
  localparam int unsigned CB_DTR  = 0;
  localparam int unsigned CB_RTS  = 1;
  localparam int unsigned CB_AUTO = 5;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/line_change_flag.sv
module line_change_flag #(
  parameter bit FALL_ONLY = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q, edge_det, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  generate
    if (FALL_ONLY) begin : g_fall
      assign edge_det = prev_q & ~level_i;
    end else begin : g_any
      assign edge_det = prev_q ^ level_i;
    end
  endgenerate

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (edge_det) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_det |=> flag_o); // R6

  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !edge_det) |=> !flag_o); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !edge_det) |=> !flag_o); // R3

  generate
    if (FALL_ONLY) begin : g_rise_chk
      AST_RISE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!flag_o && !prev_q && level_i) |=> !flag_o); // R4
    end
  endgenerate
endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
  import modem_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              stat_we_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              flow_mode_o
);
  logic dtr_q, rts_q, auto_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dtr_q  <= 1'b0;
      rts_q  <= 1'b0;
      auto_q <= 1'b0;
    end else if (ctrl_we_i) begin
      dtr_q  <= wdata_i[CB_DTR];
      rts_q  <= wdata_i[CB_RTS];
      auto_q <= wdata_i[CB_AUTO];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= 1'b0;
    else if (stat_we_i) mode_q <= wdata_i[FLOW_MODE_BIT];
  end

  always_comb begin
    ctrl_o          = '0;
    ctrl_o[CB_DTR]  = dtr_q;
    ctrl_o[CB_RTS]  = rts_q;
    ctrl_o[CB_AUTO] = auto_q;
  end

  assign flow_mode_o = mode_q;

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[7:6], wdata_i[4:2]};

  AST_CTRL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_o)); // R9

  AST_MODE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we_i |=> $stable(flow_mode_o)); // R8
endmodule

// File: rtl/modem_line_monitor.sv
module modem_line_monitor
  import modem_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dcd_i,
  input  logic              ri_i,
  input  logic              dsr_i,
  input  logic              cts_i,
  input  logic              stat_we_i,
  input  logic              ctrl_we_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              auto_flow_o,
  output logic              chg_irq_o
);
  logic [NUM_LINES-1:0] raw_lines, sync_lines, flags, clr;
  logic                 flow_mode;

  always_comb begin
    raw_lines         = '0;
    raw_lines[LN_CTS] = cts_i;
    raw_lines[LN_DSR] = dsr_i;
    raw_lines[LN_RI]  = ri_i;
    raw_lines[LN_DCD] = dcd_i;
  end

  line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_lines),
    .q_o    (sync_lines)
  );

  assign clr = stat_we_i ? wdata_i[NUM_LINES-1:0] : '0;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_change_flag #(.FALL_ONLY(g == LN_RI)) u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (sync_lines[g]),
      .clr_i   (clr[g]),
      .flag_o  (flags[g])
    );
  end

  modem_ctrl_reg u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_we_i),
    .stat_we_i   (stat_we_i),
    .wdata_i     (wdata_i),
    .ctrl_o      (ctrl_o),
    .flow_mode_o (flow_mode)
  );

  assign stat_o      = {flow_mode, sync_lines, flags};
  assign dtr_o       = ctrl_o[CB_DTR];
  assign rts_o       = ctrl_o[CB_RTS];
  assign auto_flow_o = ctrl_o[CB_AUTO];
  assign chg_irq_o   = |flags;

  AST_IRQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_irq_o && !stat_we_i) |=> chg_irq_o); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chg_irq_o) |-> (stat_o[NUM_LINES-1:0] != '0)); // R7
endmodule

// File: tb/modem_line_monitor_tb.sv
module modem_line_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dcd = 0, ri = 0, dsr = 0, cts = 0;
  logic       swe = 0, cwe = 0;
  logic [8:0] wd = '0;
  logic [8:0] stat;
  logic [5:0] ctrl;
  logic       dtr, rts, afc, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [3:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_flag = '0;
  logic       m_fm = 0;
  logic [2:0] m_ctrl = '0; // {auto, rts, dtr}

  always #2 clk = ~clk;

  modem_line_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dcd_i(dcd), .ri_i(ri), .dsr_i(dsr), .cts_i(cts),
    .stat_we_i(swe), .ctrl_we_i(cwe), .wdata_i(wd), .stat_o(stat), .ctrl_o(ctrl),
    .dtr_o(dtr), .rts_o(rts), .auto_flow_o(afc), .chg_irq_o(irq)
  );

  function automatic logic [3:0] edges(input logic [3:0] prev, input logic [3:0] cur);
    logic [3:0] e;
    e    = prev ^ cur;
    e[2] = prev[2] & ~cur[2]; // ring: falling only
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 levels", 32'(stat[7:4]), 32'(m_s2));
    chk("R3 flags dcd/dsr/cts", 32'({stat[3], stat[1:0]}), 32'({m_flag[3], m_flag[1:0]}));
    chk("R4 ring flag", 32'(stat[2]), 32'(m_flag[2]));
    chk("R8 flow mode", 32'(stat[8]), 32'(m_fm));
    chk("R7 irq", 32'(irq), 32'(|m_flag));
    chk("R9 ctrl", 32'({ctrl, dtr, rts, afc}),
        32'({m_ctrl[2], 3'b000, m_ctrl[1], m_ctrl[0], m_ctrl[0], m_ctrl[1], m_ctrl[2]}));
  endtask

  // drive one cycle of inputs (pins = {dcd,ri,dsr,cts}), advance model, check at next negedge
  task automatic cyc(input logic [3:0] p, input logic s, input logic c, input logic [8:0] w);
    {dcd, ri, dsr, cts} = p;
    swe = s; cwe = c; wd = w;
    m_flag = edges(m_prev, m_s2) | (m_flag & ~(s ? w[3:0] : 4'b0));
    if (s) m_fm = w[8];
    if (c) m_ctrl = {w[5], w[1], w[0]};
    m_prev = m_s2; m_s2 = m_s1; m_s1 = p;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] pins;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 stat", 32'(stat), 0);
    chk("R1 ctrl", 32'({ctrl, dtr, rts, afc, irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    pins = 4'b0000;

    // R3: cts rises, flag appears on the third edge
    cyc(4'b0001, 0, 0, 0);
    cyc(4'b0001, 0, 0, 0);
    chk("R2 cts level after 2 edges", 32'(stat[4]), 1);
    chk("R3 cts flag not yet", 32'(stat[0]), 0);
    cyc(4'b0001, 0, 0, 0);
    chk("R3 cts flag set", 32'(stat[0]), 1);
    chk("R7 irq on flag", 32'(irq), 1);
    // R5: writing 0 leaves it, writing 1 clears it
    cyc(4'b0001, 1, 0, 9'h002);
    chk("R5 write-0 keeps flag", 32'(stat[0]), 1);
    cyc(4'b0001, 1, 0, 9'h001);
    chk("R5 write-1 clears flag", 32'(stat[0]), 0);
    chk("R7 irq drops", 32'(irq), 0);
    // R6: dsr edge lands in the same cycle as its clear
    cyc(4'b0011, 0, 0, 0);
    cyc(4'b0011, 0, 0, 0);
    cyc(4'b0011, 1, 0, 9'h002);
    chk("R6 edge beats clear", 32'(stat[1]), 1);
    cyc(4'b0011, 1, 0, 9'h00F);
    // R4: ring rise ignored, fall flagged
    repeat (3) cyc(4'b0111, 0, 0, 0);
    chk("R4 ring rise ignored", 32'(stat[2]), 0);
    chk("R2 ring level", 32'(stat[6]), 1);
    repeat (3) cyc(4'b0011, 0, 0, 0);
    chk("R4 ring fall flagged", 32'(stat[2]), 1);
    cyc(4'b0011, 1, 0, 9'h104);
    chk("R8 flow mode set", 32'(stat[8]), 1);
    // R9 controls
    cyc(4'b0011, 0, 1, 9'h023);
    chk("R9 dtr/rts/auto", 32'({dtr, rts, afc}), 3'b111);
    cyc(4'b0011, 0, 1, 9'h002);
    chk("R9 rts only", 32'({dtr, rts, afc}), 3'b010);
    pins = 4'b0011;

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] tog;
      logic       s, c;
      for (int b = 0; b < 4; b++) tog[b] = ($urandom % 8) == 0;
      pins = pins ^ tog;
      s = ($urandom % 6) == 0;
      c = ($urandom % 8) == 0;
      cyc(pins, s, c, 9'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule